// File: doc/BRIEF.md
# DDR power-up command sequencer

This block brings an SDRAM device from power-on to a usable state. After reset it walks a fixed table of eight commands, one table for a standard DDR part and one for a low-power part, chosen when the block is built. Each command is sent as a single 26-bit word on a valid/ready command port. The word holds the row address, the bank address and a three-bit RAS/CAS/WE code, each in a fixed field.

Between commands the port stays idle for a programmable number of cycles. On the low-power variant a longer power-up wait follows the first NOP. After the last command is accepted, a longer settle delay runs. The block then requests one read of the memory base address, which turns the memory on. `init_done` rises only when that read has returned. A `start` pulse given after completion runs the whole sequence again without a reset.

Top module: `ddr_init_seq`

## Requirements
- R1: The command word puts the row in bits 25:13, the bank in bits 12:11 and the command code in bits 6:4, with all other bits zero. The codes are NOP=111, PRECHARGE ALL=010, AUTO REFRESH=001 and LOAD MODE=000, and PRECHARGE ALL carries row 0x400. With the standard table and 2-beat bursts, the eight words carry these (row, bank, code) values in order: (0x000,0,NOP), (0x400,0,PRE), (0x001,1,LM), (0x121,0,LM), (0x400,0,PRE), (0x000,0,REF), (0x000,0,REF), (0x021,0,LM).
- R2: With the 4-beat burst option on the standard table, the two bank-0 mode values become 0x122 and 0x022. Everything else is unchanged.
- R3: The low-power table issues, in order: NOP, NOP, PRECHARGE ALL (row 0x400), AUTO REFRESH, AUTO REFRESH, LOAD MODE bank 0 row 0x021, LOAD MODE bank 1 row 0x000, and NOP. All rows not named are 0x000 and all banks not named are 0.
- R4: Once `cmd_valid` is high, it and `cmd_word` hold unchanged until a cycle in which `cmd_ready` is high.
- R5: After each accepted command that is neither the last nor a long-wait command, `cmd_valid` stays low for exactly CMD_GAP cycles.
- R6: On the low-power table, `cmd_valid` stays low for exactly PWRUP_WAIT cycles after the first NOP is accepted.
- R7: After the last command is accepted, `cmd_valid` and `rd_req` stay low for exactly SETTLE cycles, and then `rd_req` rises.
- R8: `rd_req` stays high until `rd_resp` is seen with it. In the next cycle `init_done` is high and `rd_req` is low, and both `cmd_valid` and `rd_req` then stay low while `init_done` is high.
- R9: `init_done` is low during reset and throughout a sequence. A `rd_resp` pulse while `rd_req` is low has no effect.
- R10: A `start` pulse during a sequence is ignored, and the sequence continues unchanged. A `start` pulse while `init_done` is high clears `init_done` in the next cycle and presents the first command again.
- R11: While reset is held, `cmd_valid`, `rd_req` and `init_done` are low. The sequence begins by itself after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restart request, honoured only when done |
| cmd_ready | input | 1 | Command port accepts the word this cycle |
| cmd_valid | output | 1 | Command word is presented |
| cmd_word | output | 26 | Packed row/bank/code command word |
| rd_resp | input | 1 | The enabling read has returned |
| rd_req | output | 1 | Request the read of the memory base |
| init_done | output | 1 | Initialization complete |

## Verification
The bench builds three copies side by side. The first uses the standard table with 2-beat bursts, a one-cycle gap and a three-cycle settle, so back-to-back timing and the minimum counter loads are reached. The second uses the 4-beat burst option with a five-cycle gap and the full 100-cycle settle. The third uses the low-power table with a 40-cycle power-up wait, so the per-entry long wait can be seen apart from the ordinary gap. Every copy gets random ready and read-return delays from a fixed seed, plus directed stray `start` and `rd_resp` pulses and a restart after completion.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
   localparam int ROW_W   = 13;
   localparam int BANK_W  = 2;
   localparam int CODE_W  = 3;
   localparam int WORD_W  = 26;
   localparam int ROW_LSB  = 13;
   localparam int BANK_LSB = 11;
   localparam int CODE_LSB = 4;
   localparam int N_ENT    = 8;
   localparam int IDX_W    = $clog2(N_ENT);

   typedef logic [CODE_W-1:0] code_t;
   localparam code_t C_NOP = 3'b111;
   localparam code_t C_PRE = 3'b010;
   localparam code_t C_REF = 3'b001;
   localparam code_t C_LMR = 3'b000;

   typedef enum logic [2:0] {
      ST_BOOT, ST_ISSUE, ST_GAP, ST_SETTLE, ST_READ, ST_DONE
   } seq_state_t;

   function automatic logic [WORD_W-1:0] pack_cmd(
      input logic [ROW_W-1:0] row, input logic [BANK_W-1:0] bank, input code_t code);
      logic [WORD_W-1:0] w;
      w = '0;
      w[ROW_LSB  +: ROW_W]  = row;
      w[BANK_LSB +: BANK_W] = bank;
      w[CODE_LSB +: CODE_W] = code;
      return w;
   endfunction
endpackage

// File: rtl/ddr_init_table.sv
module ddr_init_table
   import ddr_init_pkg::*;
#(
   parameter bit LPDDR = 1'b0,
   parameter bit BL4   = 1'b0
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [WORD_W-1:0] word,
   output logic              long_wait
);
   localparam logic [ROW_W-1:0] MODE_DLL_RST = BL4 ? 13'h122 : 13'h121;
   localparam logic [ROW_W-1:0] MODE_RUN     = BL4 ? 13'h022 : 13'h021;
   localparam logic [ROW_W-1:0] ROW_A10      = 13'h400;

   generate
      if (LPDDR) begin : g_lp
         always_comb begin
            long_wait = (idx == '0);
            case (idx)
               3'd0, 3'd1, 3'd7: word = pack_cmd('0, 2'd0, C_NOP);
               3'd2:             word = pack_cmd(ROW_A10, 2'd0, C_PRE);
               3'd3, 3'd4:       word = pack_cmd('0, 2'd0, C_REF);
               3'd5:             word = pack_cmd(13'h021, 2'd0, C_LMR);
               default:          word = pack_cmd('0, 2'd1, C_LMR);
            endcase
         end
      end else begin : g_std
         always_comb begin
            long_wait = 1'b0;
            case (idx)
               3'd0:       word = pack_cmd('0, 2'd0, C_NOP);
               3'd1, 3'd4: word = pack_cmd(ROW_A10, 2'd0, C_PRE);
               3'd2:       word = pack_cmd(13'h001, 2'd1, C_LMR);
               3'd3:       word = pack_cmd(MODE_DLL_RST, 2'd0, C_LMR);
               3'd5, 3'd6: word = pack_cmd('0, 2'd0, C_REF);
               default:    word = pack_cmd(MODE_RUN, 2'd0, C_LMR);
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter bit LPDDR      = 1'b0,
   parameter bit BL4        = 1'b0,
   parameter int CMD_GAP    = 4,
   parameter int SETTLE     = 100,
   parameter int PWRUP_WAIT = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cmd_ready,
   output logic              cmd_valid,
   output logic [WORD_W-1:0] cmd_word,
   input  logic              rd_resp,
   output logic              rd_req,
   output logic              init_done
);
   localparam int MAX_WAIT = (SETTLE > CMD_GAP) ?
                             ((SETTLE > PWRUP_WAIT) ? SETTLE : PWRUP_WAIT) :
                             ((CMD_GAP > PWRUP_WAIT) ? CMD_GAP : PWRUP_WAIT);
   localparam int CW = $clog2(MAX_WAIT + 1);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

   generate
      if (CMD_GAP < 1)    begin : g_bad_gap    $error("CMD_GAP must be at least 1"); end
      if (SETTLE < 1)     begin : g_bad_settle $error("SETTLE must be at least 1"); end
      if (PWRUP_WAIT < 1) begin : g_bad_pwr    $error("PWRUP_WAIT must be at least 1"); end
   endgenerate

   seq_state_t       state;
   logic [IDX_W-1:0] idx;
   logic             long_wait;
   logic             accept;
   logic             t_zero;
   logic [CW-1:0]    t_load_val;

   ddr_init_table #(.LPDDR(LPDDR), .BL4(BL4)) u_table (
      .idx(idx), .word(cmd_word), .long_wait(long_wait));

   assign cmd_valid = (state == ST_ISSUE);
   assign rd_req    = (state == ST_READ);
   assign init_done = (state == ST_DONE);
   assign accept    = cmd_valid && cmd_ready;

   always_comb begin
      if (idx == LAST)    t_load_val = CW'(SETTLE - 1);
      else if (long_wait) t_load_val = CW'(PWRUP_WAIT - 1);
      else                t_load_val = CW'(CMD_GAP - 1);
   end

   ddr_init_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .load_val(t_load_val), .zero(t_zero));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_BOOT;
         idx   <= '0;
      end else begin
         case (state)
            ST_BOOT:  state <= ST_ISSUE;
            ST_ISSUE: if (accept) state <= (idx == LAST) ? ST_SETTLE : ST_GAP;
            ST_GAP: if (t_zero) begin
               idx   <= idx + 1'b1;
               state <= ST_ISSUE;
            end
            ST_SETTLE: if (t_zero) state <= ST_READ;
            ST_READ:   if (rd_resp) state <= ST_DONE;
            ST_DONE: if (start) begin
               idx   <= '0;
               state <= ST_ISSUE;
            end
            default:   state <= ST_BOOT;
         endcase
      end
   end

   a_r4_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word));
   a_r5_idle_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> !cmd_valid);
   a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_resp |=> rd_req);
   a_r8_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && rd_resp |=> init_done && !rd_req);
   a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> !cmd_valid && !rd_req);
   a_r9_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid || rd_req) |=> !init_done || $past(rd_req));
endmodule

// File: tb/test_ddr_init_seq.sv
module ddr_init_agent #(
   parameter bit LP = 1'b0,
   parameter bit B4 = 1'b0,
   parameter int GAP = 1,
   parameter int SET = 3,
   parameter int PWR = 40,
   parameter int SEED = 1
) (
   input  logic clk,
   input  logic rst_n,
   output int   nchk,
   output int   nerr,
   output logic fin
);
   logic start, cmd_ready, rd_resp;
   logic cmd_valid, rd_req, init_done;
   logic [25:0] cmd_word;

   ddr_init_seq #(.LPDDR(LP), .BL4(B4), .CMD_GAP(GAP), .SETTLE(SET), .PWRUP_WAIT(PWR))
   i_ddr_init_seq (.clk(clk), .rst_n(rst_n), .start(start), .cmd_ready(cmd_ready),
      .cmd_valid(cmd_valid), .cmd_word(cmd_word), .rd_resp(rd_resp),
      .rd_req(rd_req), .init_done(init_done));

   function automatic logic [25:0] mk(input int row, input int bank, input int code);
      return 26'((row << 13) | (bank << 11) | (code << 4));
   endfunction

   function automatic logic [25:0] exp_word(input int i);
      if (LP) begin
         case (i)
            0, 1, 7: return mk(0, 0, 7);
            2:       return mk('h400, 0, 2);
            3, 4:    return mk(0, 0, 1);
            5:       return mk('h021, 0, 0);
            default: return mk(0, 1, 0);
         endcase
      end else begin
         case (i)
            0:       return mk(0, 0, 7);
            1, 4:    return mk('h400, 0, 2);
            2:       return mk('h001, 1, 0);
            3:       return mk(B4 ? 'h122 : 'h121, 0, 0);
            5, 6:    return mk(0, 0, 1);
            default: return mk(B4 ? 'h022 : 'h021, 0, 0);
         endcase
      end
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s (lp=%0d bl4=%0d) actual=%0h expected=%0h", tag, LP, B4, act, expv);
      end
   endtask

   task automatic run_seq();
      int lowcnt;
      bit r;
      logic [25:0] held;
      for (int i = 0; i < 8; i++) begin
         lowcnt = 0;
         while (!cmd_valid) begin
            chk(init_done == 1'b0, "R9 done low mid-sequence", int'(init_done), 0);
            lowcnt++;
            start   = (i == 4 && lowcnt == 1);
            rd_resp = (i == 2 && lowcnt == 1);
            cmd_ready = 1'($urandom % 2);
            @(negedge clk);
         end
         start = 0; rd_resp = 0;
         if (i == 1 && LP) chk(lowcnt == PWR, "R6 power-up wait", lowcnt, PWR);
         else if (i > 0)   chk(lowcnt == GAP, "R5 command gap", lowcnt, GAP);
         if (LP)           chk(cmd_word == exp_word(i), "R3 low-power word", int'(cmd_word), int'(exp_word(i)));
         else if (B4)      chk(cmd_word == exp_word(i), "R2 burst-4 word", int'(cmd_word), int'(exp_word(i)));
         else              chk(cmd_word == exp_word(i), "R1 standard word", int'(cmd_word), int'(exp_word(i)));
         held = cmd_word;
         forever begin
            r = ($urandom % 3) != 0;
            cmd_ready = r;
            @(negedge clk);
            if (r) break;
            chk(cmd_valid && cmd_word == held, "R4 word held", int'(cmd_word), int'(held));
         end
         cmd_ready = 0;
      end
      lowcnt = 0;
      while (!rd_req) begin
         chk(!cmd_valid && !init_done, "R7 quiet during settle", int'(cmd_valid), 0);
         lowcnt++;
         @(negedge clk);
      end
      chk(lowcnt == SET, "R7 settle length", lowcnt, SET);
      repeat ($urandom % 4) begin
         @(negedge clk);
         chk(rd_req && !init_done, "R8 read held", int'(rd_req), 1);
      end
      rd_resp = 1;
      @(negedge clk);
      rd_resp = 0;
      chk(init_done && !rd_req, "R8 done after read", int'(init_done), 1);
      repeat (3) @(negedge clk);
      chk(init_done && !cmd_valid && !rd_req, "R8 done stays quiet", int'(init_done), 1);
   endtask

   initial begin
      int unused;
      nchk = 0; nerr = 0; fin = 0;
      start = 0; cmd_ready = 0; rd_resp = 0;
      unused = $urandom(SEED);
      @(negedge clk);
      chk(!cmd_valid && !rd_req && !init_done, "R11 reset state",
          int'({cmd_valid, rd_req, init_done}), 0);
      while (!rst_n) @(negedge clk);
      run_seq();
      start = 1;
      @(negedge clk);
      start = 0;
      chk(!init_done && cmd_valid, "R10 restart", int'({init_done, cmd_valid}), 1);
      chk(cmd_word == exp_word(0), "R10 restart word", int'(cmd_word), int'(exp_word(0)));
      run_seq();
      fin = 1;
   end
endmodule

module test_ddr_init_seq;
   logic clk = 0;
   logic rst_n = 0;
   int c0, e0, c1, e1, c2, e2;
   logic f0, f1, f2;
   int wd_err = 0;

   always #2 clk = ~clk;

   ddr_init_agent #(.LP(0), .B4(0), .GAP(1), .SET(3),   .PWR(40), .SEED(11))
      i_ddr_init_seq (.clk(clk), .rst_n(rst_n), .nchk(c0), .nerr(e0), .fin(f0));
   ddr_init_agent #(.LP(0), .B4(1), .GAP(5), .SET(100), .PWR(40), .SEED(22))
      i_ag_bl4 (.clk(clk), .rst_n(rst_n), .nchk(c1), .nerr(e1), .fin(f1));
   ddr_init_agent #(.LP(1), .B4(0), .GAP(2), .SET(7),   .PWR(40), .SEED(33))
      i_ag_lp (.clk(clk), .rst_n(rst_n), .nchk(c2), .nerr(e2), .fin(f2));

   initial begin
      int cyc;
      repeat (5) @(negedge clk);
      rst_n = 1;
      cyc = 0;
      while (!(f0 && f1 && f2) && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      if (!(f0 && f1 && f2)) begin
         wd_err = 1;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("Result: errors=%0d of %0d checks", e0 + e1 + e2 + wd_err, c0 + c1 + c2 + wd_err);
      $finish;
   end
endmodule